// File: doc/BRIEF.md
# Colour Subcarrier Phase Oscillator

This block is a numerically controlled oscillator that produces the running phase of a colour subcarrier. A 32-bit accumulator adds a programmed frequency step on every clock. The output frequency is therefore the clock frequency times the step, divided by 2^32. For example, a step of 0x21F07C16 on a 27 MHz clock gives about 3.5795454 MHz. The top eight bits of the accumulator, plus an 8-bit phase trim, form the output word. That word is meant to address a sine lookup placed after this block.

Software writes the step one byte at a time through a small write port. Bytes 0 to 2 go into holding registers. Writing byte 3 moves all four bytes into the live step on the same edge, so the oscillator never runs on a step that is only half updated. Index 4 holds the phase trim. One trim LSB is 360/256 degrees, about 1.41 degrees, and the trim is 0x00 in normal use. A clear input restarts the accumulator at zero and keeps the programmed step.

Top module: `subcarrier_nco`

## Requirements
- R1: After synchronous reset the live step, the holding bytes, the trim and the accumulator are all zero, so `phase_out` reads 0x00 and stays there until a step is committed.
- R2: On every clock edge without clear, the accumulator advances by the live step modulo 2^32. `phase_out` is accumulator bits 31:24 plus the trim, modulo 256, and it shows the new value in the cycle after the edge.
- R3: Write index 0 carries step bits 7:0, index 1 bits 15:8, index 2 bits 23:16 and index 3 bits 31:24.
- R4: A write to index 0, 1 or 2 leaves the live step unchanged. A write to index 3 commits all four bytes on that edge, and the accumulator adds the new step from the next edge on.
- R5: A write to index 4 loads the trim, which appears in `phase_out` in the cycle after the write edge. The trim wraps modulo 256 when it is added to the top byte.
- R6: `acc_clr` high at an edge sets the accumulator to zero, taking precedence over the step add. The live step is kept, so accumulation resumes with the same step once the clear is released.
- R7: Writes to indices 5, 6 and 7 change no state.
- R8: A step of 0x40000000 makes `phase_out` repeat 0x00, 0x40, 0x80, 0xC0 with a period of four clocks. This shows the output frequency is the clock frequency times the step divided by 2^32.
- R9: Changing the trim moves only the output. The accumulator keeps its course, so setting the trim back to 0 restores the untrimmed phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Write index: 0-3 step bytes, 4 phase trim |
| wr_data | input | 8 | Write data byte |
| acc_clr | input | 1 | Zero the accumulator at the next edge |
| phase_out | output | 8 | Trimmed top byte of phase |

## Verification
A wrong accumulator value shows up at `phase_out` in the very next cycle whenever the error touches bits 31:24. An error in the lower bits first shows up when its carry reaches the top byte. For a step of a large size, that takes only a few cycles.

A holding byte that is corrupted, or a step committed too early, stays hidden until the next commit or until the step diverges. From that point on, every following cycle drifts from the expected ramp. A trim fault offsets the output at once, while the accumulator keeps its own course.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int ACC_W     = 32;
    localparam int BYTE_W    = 8;
    localparam int OUT_W     = 8;
    localparam int NUM_LANES = ACC_W / BYTE_W;
    localparam int ADDR_W    = 3;
    localparam int TRIM_IDX  = NUM_LANES;
    localparam int LOW_W     = ACC_W - BYTE_W;

    typedef logic [ACC_W-1:0]  phase_word_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [OUT_W-1:0]  phase_out_t;
    typedef logic [ADDR_W-1:0] idx_t;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_LANE,
        WR_COMMIT,
        WR_TRIM
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e kind;
        idx_t     lane;
        byte_t    data;
    } wr_req_t;

    function automatic wr_kind_e classify(input logic en, input idx_t a);
        int idx;
        idx = int'(a);
        if (!en)
            return WR_NONE;
        else if (idx == NUM_LANES - 1)
            return WR_COMMIT;
        else if (idx < NUM_LANES - 1)
            return WR_LANE;
        else if (idx == TRIM_IDX)
            return WR_TRIM;
        else
            return WR_NONE;
    endfunction

endpackage

// File: rtl/nco_wr_decode.sv
module nco_wr_decode
    import nco_pkg::*;
(
    input  logic    wr_en,
    input  idx_t    wr_addr,
    input  byte_t   wr_data,
    output wr_req_t req
);

    always_comb begin
        req.kind = classify(wr_en, wr_addr);
        req.lane = wr_addr;
        req.data = wr_data;
    end

endmodule

// File: rtl/nco_incr_regs.sv
module nco_incr_regs
    import nco_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  wr_req_t     req,
    output phase_word_t step
);

    byte_t             hold [NUM_LANES-1];
    logic [LOW_W-1:0]  low_word;
    phase_word_t       step_q;

    for (genvar g = 0; g < NUM_LANES - 1; g++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst)
                hold[g] <= '0;
            else if (req.kind == WR_LANE && int'(req.lane) == g)
                hold[g] <= req.data;
        end
        assign low_word[g*BYTE_W +: BYTE_W] = hold[g];
    end

    always_ff @(posedge clk) begin
        if (rst)
            step_q <= '0;
        else if (req.kind == WR_COMMIT)
            step_q <= {req.data, low_word};
    end

    assign step = step_q;

    // R4
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req.kind != WR_COMMIT) |=> $stable(step_q));

    // R3
    step_top_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (req.kind == WR_COMMIT) |=> (step_q[ACC_W-1 -: BYTE_W] == $past(req.data)));

    // R7
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req.kind == WR_NONE) |=> ($stable(step_q) && $stable(low_word)));

endmodule

// File: rtl/nco_accum.sv
module nco_accum
    import nco_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  phase_word_t step,
    output phase_out_t  acc_top
);

    phase_word_t acc_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc_q <= '0;
        else
            acc_q <= acc_q + step;
    end

    assign acc_top = acc_q[ACC_W-1 -: OUT_W];

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0));

    // R2
    acc_advance_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (acc_q - $past(acc_q) == $past(step)));

endmodule

// File: rtl/nco_trim.sv
module nco_trim
    import nco_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trim_we,
    input  byte_t      trim_data,
    input  phase_out_t acc_top,
    output phase_out_t phase_out
);

    byte_t trim_q;

    always_ff @(posedge clk) begin
        if (rst)
            trim_q <= '0;
        else if (trim_we)
            trim_q <= trim_data;
    end

    assign phase_out = acc_top + phase_out_t'(trim_q);

    // R5
    trim_load_chk: assert property (@(posedge clk) disable iff (rst)
        trim_we |=> (trim_q == $past(trim_data)));

    // R9
    trim_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !trim_we |=> $stable(trim_q));

endmodule

// File: rtl/subcarrier_nco.sv
module subcarrier_nco
    import nco_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                acc_clr,
    output logic [OUT_W-1:0]    phase_out
);

    wr_req_t     req;
    phase_word_t step;
    phase_out_t  acc_top;

    nco_wr_decode i_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .req     (req)
    );

    nco_incr_regs i_incr (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .step (step)
    );

    nco_accum i_accum (
        .clk     (clk),
        .rst     (rst),
        .clr     (acc_clr),
        .step    (step),
        .acc_top (acc_top)
    );

    nco_trim i_trim (
        .clk       (clk),
        .rst       (rst),
        .trim_we   (req.kind == WR_TRIM),
        .trim_data (req.data),
        .acc_top   (acc_top),
        .phase_out (phase_out)
    );

    // R1
    reset_out_chk: assert property (@(posedge clk)
        rst |=> (phase_out == '0));

endmodule

// File: tb/test_subcarrier_nco.sv
module test_subcarrier_nco;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       acc_clr = 1'b0;
    logic [7:0] phase_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    longint     m_acc = 0;
    longint     m_inc = 0;
    logic [7:0] m_hold [3];
    int         m_trim = 0;

    always #2 clk = ~clk;

    subcarrier_nco i_subcarrier_nco (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .acc_clr   (acc_clr),
        .phase_out (phase_out)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_acc <= 0;
            m_inc <= 0;
            m_trim <= 0;
            for (int i = 0; i < 3; i++) m_hold[i] <= '0;
        end else begin
            if (acc_clr) m_acc <= 0;
            else         m_acc <= (m_acc + m_inc) % 64'h1_0000_0000;
            if (wr_en) begin
                if (wr_addr < 3)
                    m_hold[wr_addr] <= wr_data;
                else if (wr_addr == 3)
                    m_inc <= longint'(wr_data) * 64'h100_0000 + longint'(m_hold[2]) * 64'h1_0000
                             + longint'(m_hold[1]) * 64'h100 + longint'(m_hold[0]);
                else if (wr_addr == 4)
                    m_trim <= int'(wr_data);
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: phase_out=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done)
            chk(cur_req, phase_out, 8'(((m_acc >> 24) + m_trim) % 256));
    end

    task automatic wr(input int idx, input logic [7:0] d);
        wr_en = 1'b1;
        wr_addr = 3'(idx);
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clr();
        acc_clr = 1'b1;
        @(negedge clk);
        acc_clr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle output after reset
        cur_req = "R1";
        chk("R1", phase_out, 8'h00);
        repeat (4) @(negedge clk);
        chk("R1", phase_out, 8'h00);

        // R3: byte lanes build 0x21F07C16
        cur_req = "R3";
        wr(0, 8'h16); wr(1, 8'h7C); wr(2, 8'hF0); wr(3, 8'h21);
        repeat (10) @(negedge clk);
        pulse_clr();
        chk("R6", phase_out, 8'h00);
        repeat (3) @(negedge clk);
        chk("R3", phase_out, 8'h65);

        // R4: lanes 0-2 do not alter live step
        cur_req = "R4";
        wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);
        pulse_clr();
        repeat (2) @(negedge clk);
        chk("R4", phase_out, 8'h43);
        wr(3, 8'h40);

        // R8: period of four clocks
        cur_req = "R8";
        pulse_clr();
        chk("R8", phase_out, 8'h00);
        @(negedge clk); chk("R8", phase_out, 8'h40);
        @(negedge clk); chk("R8", phase_out, 8'h80);
        @(negedge clk); chk("R8", phase_out, 8'hC0);
        @(negedge clk); chk("R8", phase_out, 8'h00);

        // R5: trim with modulo wrap
        cur_req = "R5";
        wr(4, 8'hF0);
        pulse_clr();
        chk("R5", phase_out, 8'hF0);
        @(negedge clk); chk("R5", phase_out, 8'h30);

        // R7: indices 5..7 ignored
        cur_req = "R7";
        wr(5, 8'hAA); wr(6, 8'h55); wr(7, 8'hFF);
        pulse_clr();
        chk("R7", phase_out, 8'hF0);
        @(negedge clk); chk("R7", phase_out, 8'h30);

        // R6: held clear keeps step
        cur_req = "R6";
        acc_clr = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6", phase_out, 8'hF0);
        acc_clr = 1'b0;
        @(negedge clk); chk("R6", phase_out, 8'h30);

        // R9: trim back to zero restores ramp
        cur_req = "R9";
        wr(4, 8'h00);
        chk("R9", phase_out, 8'h80);

        // R2: mixed random traffic against the model
        cur_req = "R2";
        for (int n = 0; n < 400; n++) begin
            wr_en   = ($urandom % 3) == 0;
            wr_addr = 3'($urandom % 8);
            wr_data = 8'($urandom);
            acc_clr = ($urandom % 23) == 0;
            @(negedge clk);
        end
        wr_en = 1'b0;
        acc_clr = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule